// File: doc/BRIEF.md
# Barrel-Threaded Program Counter Controller

This block is the control unit of an interleaved, in-order pipeline that runs eight hardware threads. It holds one program counter per thread. On every clock it presents one thread's index and PC to the instruction memory, and the threads take turns in a fixed round-robin order. The pipeline has no result forwarding and no interlocks. It stays hazard-free because a thread issues again only after all other threads have had a slot, and the longest operand-to-ALU loop is no longer than that rotation.

When a thread's instruction issues, its PC advances by one. When the instruction later retires, the pipeline hands back the thread index, a two-bit branch code, the A operand and the branch target. The controller decides whether the branch is taken and, if so, overwrites that thread's PC with the target. A retire can arrive after the thread has already issued its next instruction, which happens on the longer path through the instruction memory. In that case the instruction after the branch still runs with the sequential PC, and the target takes effect from the following issue. That instruction is the delay slot.

Top module: `barrel_pc_ctrl`

## Requirements
- R1: Asynchronous active-low reset selects thread 0 as the next issuer and sets the PC of thread t to START_BASE + t*START_STRIDE (default 0 + t*64).
- R2: The issued thread index advances by one on every clock and wraps from NUM_THREADS-1 to 0.
- R3: The issue PC output equals the current PC of the issuing thread. Without a taken branch, that thread's next issue carries PC+1.
- R4: Branch code 1 (always) with a valid retire is always taken, and the thread's PC becomes the target.
- R5: Branch code 2 (if zero) is taken only when the A operand equals zero.
- R6: Branch code 3 (if negative) is taken only when the most significant bit of the A operand is set.
- R7: Branch code 0 (no branch) is never taken and leaves the retiring thread's PC unchanged.
- R8: If a taken retire names the thread that is issuing in the same cycle, that issue uses the old PC and the thread's next issue uses the target. This is the delay slot.
- R9: A retire with the valid input low has no effect on any PC, and the taken output stays low.
- R10: The PC increment wraps modulo 2^PC_W (1023 + 1 gives 0 at default width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ret_valid_i | input | 1 | A retiring instruction is presented |
| ret_thread_i | input | 3 | Thread index of the retiring instruction |
| ret_op_i | input | 2 | Branch code: 0 none, 1 always, 2 if zero, 3 if negative |
| ret_a_i | input | DATA_W (36) | A operand that the branch condition tests |
| ret_target_i | input | PC_W (10) | Branch target address |
| issue_thread_o | output | 3 | Thread issuing this cycle |
| issue_pc_o | output | PC_W (10) | PC sent to the instruction memory |
| br_taken_o | output | 1 | The retiring branch is taken this cycle |

## Verification
The bench targets four corner cases. The first is a retire that lands on the thread issuing in the same cycle. A design that gave the load priority over the current issue, or that let the increment overwrite the target, would lose the delay slot or drop the branch. The second is the if-zero and if-negative codes driven with boundary operands (zero, one, the most negative value, all ones); a sign test on the wrong bit or a zero test that ignores the upper bits would take the wrong branch. The third is retires with valid low but a jump code, which a design that ignores the valid qualifier would act on. The fourth is a jump to the top address followed by sequential issues, which exposes a PC increment that saturates or widens instead of wrapping.

// File: rtl/barrel_pc_pkg.sv
package barrel_pc_pkg;
  typedef enum logic [1:0] {
    BR_NONE   = 2'd0,
    BR_ALWAYS = 2'd1,
    BR_ZERO   = 2'd2,
    BR_NEG    = 2'd3
  } br_op_e;
endpackage

// File: rtl/thread_rotor.sv
module thread_rotor #(
  parameter int NUM_THREADS = 8,
  localparam int THR_W = $clog2(NUM_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [THR_W-1:0] thr_o
);
  localparam logic [THR_W-1:0] LAST = THR_W'(NUM_THREADS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          thr_o <= '0;
    else if (thr_o == LAST) thr_o <= '0;
    else                  thr_o <= thr_o + 1'b1;
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import barrel_pc_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              valid_i,
  input  br_op_e            op_i,
  input  logic [DATA_W-1:0] a_i,
  output logic              taken_o
);
  logic cond;

  always_comb begin
    unique case (op_i)
      BR_ALWAYS: cond = 1'b1;
      BR_ZERO:   cond = (a_i == '0);
      BR_NEG:    cond = a_i[DATA_W-1];
      default:   cond = 1'b0;
    endcase
    taken_o = valid_i & cond;
  end
endmodule

// File: rtl/pc_file.sv
module pc_file #(
  parameter int NUM_THREADS  = 8,
  parameter int PC_W         = 10,
  parameter int START_BASE   = 0,
  parameter int START_STRIDE = 64,
  localparam int THR_W = $clog2(NUM_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] iss_thr_i,
  input  logic             ld_en_i,
  input  logic [THR_W-1:0] ld_thr_i,
  input  logic [PC_W-1:0]  ld_pc_i,
  output logic [PC_W-1:0]  iss_pc_o
);
  logic [PC_W-1:0] pc_q [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam logic [PC_W-1:0] RST_PC = PC_W'(START_BASE + t * START_STRIDE);
    logic hit_iss, hit_ld;
    assign hit_iss = (iss_thr_i == THR_W'(t));
    assign hit_ld  = ld_en_i && (ld_thr_i == THR_W'(t));

    // load beats increment: the same-slot issue becomes the delay slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pc_q[t] <= RST_PC;
      else if (hit_ld)  pc_q[t] <= ld_pc_i;
      else if (hit_iss) pc_q[t] <= pc_q[t] + 1'b1;
    end
  end

  assign iss_pc_o = pc_q[iss_thr_i];
endmodule

// File: rtl/barrel_pc_ctrl.sv
module barrel_pc_ctrl
  import barrel_pc_pkg::*;
#(
  parameter int NUM_THREADS  = 8,
  parameter int PC_W         = 10,
  parameter int DATA_W       = 36,
  parameter int START_BASE   = 0,
  parameter int START_STRIDE = 64,
  localparam int THR_W = $clog2(NUM_THREADS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ret_valid_i,
  input  logic [THR_W-1:0]  ret_thread_i,
  input  logic [1:0]        ret_op_i,
  input  logic [DATA_W-1:0] ret_a_i,
  input  logic [PC_W-1:0]   ret_target_i,
  output logic [THR_W-1:0]  issue_thread_o,
  output logic [PC_W-1:0]   issue_pc_o,
  output logic              br_taken_o
);
  logic [THR_W-1:0] thr;
  logic             taken;

  thread_rotor #(.NUM_THREADS(NUM_THREADS)) u_rotor (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .thr_o (thr)
  );

  branch_resolve #(.DATA_W(DATA_W)) u_br (
    .valid_i(ret_valid_i),
    .op_i   (br_op_e'(ret_op_i)),
    .a_i    (ret_a_i),
    .taken_o(taken)
  );

  pc_file #(
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .START_BASE  (START_BASE),
    .START_STRIDE(START_STRIDE)
  ) u_pcs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .iss_thr_i(thr),
    .ld_en_i  (taken),
    .ld_thr_i (ret_thread_i),
    .ld_pc_i  (ret_target_i),
    .iss_pc_o (issue_pc_o)
  );

  assign issue_thread_o = thr;
  assign br_taken_o     = taken;
endmodule

// File: rtl/barrel_pc_ctrl_chk.sv
module barrel_pc_ctrl_chk #(
  parameter int NUM_THREADS = 8,
  parameter int PC_W        = 10,
  parameter int DATA_W      = 36,
  localparam int THR_W = $clog2(NUM_THREADS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ret_valid_i,
  input logic [THR_W-1:0]  ret_thread_i,
  input logic [1:0]        ret_op_i,
  input logic [DATA_W-1:0] ret_a_i,
  input logic [PC_W-1:0]   ret_target_i,
  input logic [THR_W-1:0]  issue_thread_o,
  input logic [PC_W-1:0]   issue_pc_o,
  input logic              br_taken_o
);
  localparam logic [THR_W-1:0] LAST = THR_W'(NUM_THREADS - 1);

  AST_THREAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> issue_thread_o == (($past(issue_thread_o) == LAST) ? '0 : $past(issue_thread_o) + 1'b1)); // R2

  AST_JUMP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_op_i == 2'd1) |-> br_taken_o); // R4

  AST_ZERO_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_op_i == 2'd2) |-> br_taken_o == (ret_a_i == '0)); // R5

  AST_NEG_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_op_i == 2'd3) |-> br_taken_o == ret_a_i[DATA_W-1]); // R6

  AST_NONE_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_op_i == 2'd0) |-> !br_taken_o); // R7

  AST_INVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_valid_i |-> !br_taken_o); // R9
endmodule

bind barrel_pc_ctrl barrel_pc_ctrl_chk #(
  .NUM_THREADS(NUM_THREADS),
  .PC_W       (PC_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ret_valid_i   (ret_valid_i),
  .ret_thread_i  (ret_thread_i),
  .ret_op_i      (ret_op_i),
  .ret_a_i       (ret_a_i),
  .ret_target_i  (ret_target_i),
  .issue_thread_o(issue_thread_o),
  .issue_pc_o    (issue_pc_o),
  .br_taken_o    (br_taken_o)
);

// File: tb/barrel_pc_ctrl_bench.sv
module barrel_pc_ctrl_bench;
  localparam int NT = 8;
  localparam int PW = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ret_valid = 1'b0;
  logic [2:0]    ret_thread = '0;
  logic [1:0]    ret_op = '0;
  logic [DW-1:0] ret_a = '0;
  logic [PW-1:0] ret_target = '0;
  logic [2:0]    issue_thread;
  logic [PW-1:0] issue_pc;
  logic          br_taken;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int thr_ref;
  int pc_ref [NT];

  always #10 clk = ~clk;

  barrel_pc_ctrl u_barrel_pc_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ret_valid_i   (ret_valid),
    .ret_thread_i  (ret_thread),
    .ret_op_i      (ret_op),
    .ret_a_i       (ret_a),
    .ret_target_i  (ret_target),
    .issue_thread_o(issue_thread),
    .issue_pc_o    (issue_pc),
    .br_taken_o    (br_taken)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input int rt, input int op,
                      input logic [DW-1:0] a, input int tgt);
    bit exp_taken;
    @(negedge clk);
    ret_valid  = v;
    ret_thread = 3'(rt);
    ret_op     = 2'(op);
    ret_a      = a;
    ret_target = PW'(tgt);
    #1;
    exp_taken = v && (op == 1 || (op == 2 && a == '0) || (op == 3 && a[DW-1]));
    check(tag, "thread", int'(issue_thread), thr_ref);
    check(tag, "pc", int'(issue_pc), pc_ref[thr_ref]);
    check(tag, "taken", int'(br_taken), int'(exp_taken));
    @(posedge clk);
    pc_ref[thr_ref] = (pc_ref[thr_ref] + 1) % (1 << PW);
    if (exp_taken) pc_ref[rt] = tgt;
    thr_ref = (thr_ref + 1) % NT;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 0, 0, '0, 0);
  endtask

  initial begin
    thr_ref = 0;
    for (int t = 0; t < NT; t++) pc_ref[t] = t * 64;
    #35 rst_n = 1'b1;
    // R1: start addresses visible over the first rotation
    idle("R1", NT);
    // R2, R3: plain rotation and increments
    idle("R2_R3", 2 * NT);
    // R4: jumps for several threads
    step("R4", 1'b1, 5, 1, 36'h123, 300);
    step("R4", 1'b1, 2, 1, 36'h0, 17);
    idle("R4", NT);
    // R5: zero branch with boundary operands
    step("R5", 1'b1, 1, 2, 36'h0, 500);
    step("R5", 1'b1, 3, 2, 36'h1, 600);
    step("R5", 1'b1, 4, 2, 36'h8_0000_0000, 610);
    idle("R5", NT);
    // R6: negative branch
    step("R6", 1'b1, 6, 3, 36'h8_0000_0000, 700);
    step("R6", 1'b1, 7, 3, 36'h7_FFFF_FFFF, 710);
    step("R6", 1'b1, 0, 3, 36'hF_FFFF_FFFF, 720);
    step("R6", 1'b1, 1, 3, 36'h0, 730);
    idle("R6", NT);
    // R7: no-branch code never loads
    step("R7", 1'b1, 2, 0, 36'h0, 99);
    step("R7", 1'b1, 3, 0, 36'hF_FFFF_FFFF, 98);
    idle("R7", NT);
    // R9: invalid retire with jump code ignored
    step("R9", 1'b0, 4, 1, 36'h0, 222);
    step("R9", 1'b0, 5, 2, 36'h0, 223);
    idle("R9", NT);
    // R8: retire hits the thread issuing now -> delay slot
    step("R8", 1'b1, thr_ref, 1, 36'h0, 400);
    idle("R8", NT);
    step("R8", 1'b1, thr_ref, 2, 36'h0, 401);
    idle("R8", 2 * NT);
    // R10: jump to top address, then wrap to 0
    step("R10", 1'b1, (thr_ref + 3) % NT, 1, 36'h0, 1023);
    idle("R10", 2 * NT + 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule